// File: doc/BRIEF.md
# Counter CSR Read Permission Gate

This block decides, in one combinational step, whether a read of one of the unprivileged performance counter CSRs may proceed at the current privilege level. It covers the 32 low-half counter addresses: cycle, time, instret and the general event counters 3 to 31. It also covers their 32 high-half companions, which only exist when the hart runs with 32-bit registers. It drives a single flag that the decode stage turns into an illegal-instruction exception.

The gate needs four inputs from the hart: the CSR address, the current privilege, the register width and whether virtualization is active. It also reads three 32-bit enable masks: one owned by machine mode, one owned by supervisor mode and one owned by the hypervisor. Every counter address selects the enable bit whose index is the address's offset within its 32-entry window. A high half therefore shares its bit with the matching low half. The checks stack up: the machine mask gates supervisor and user code, the supervisor mask also gates user code, and the hypervisor mask also gates any guest access below machine level.

Top module: `counter_csr_gate`

## Requirements
- R1: An address outside 0xC00..0xC1F and 0xC80..0xC9F never raises `illegal_o`, whatever the other inputs are.
- R2: For a low-half address 0xC00+n, the enable bit used is bit n of each mask. Bit 0 gates cycle, bit 1 gates time, bit 2 gates instret, and bit n gates event counter n.
- R3: With `rv32_i`=1, the high-half address 0xC80+n is gated exactly like 0xC00+n, using the same bit n.
- R4: With `rv32_i`=0, any address in 0xC80..0xC9F raises `illegal_o` in every privilege mode.
- R5: In machine mode (`priv_i`=2'b11), every low-half address is allowed. Every high-half address is also allowed when `rv32_i`=1.
- R6: In supervisor mode (`priv_i`=2'b01), a counter read is illegal when bit n of `mcnt_en_i` is 0.
- R7: In user mode (`priv_i`=2'b00), a counter read is illegal unless bit n of `mcnt_en_i` and bit n of `scnt_en_i` are both 1.
- R8: The reserved privilege code 2'b10 is gated exactly like supervisor mode.
- R9: With `virt_i`=1 and a privilege below machine, a counter read is also illegal when bit n of `hcnt_en_i` is 0. With `virt_i`=0, `hcnt_en_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| csr_addr_i | input | 12 | CSR address being read |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 2 reserved, 3 machine |
| rv32_i | input | 1 | 1 when the hart runs with 32-bit registers |
| virt_i | input | 1 | 1 when virtualization is active |
| mcnt_en_i | input | 32 | Machine-owned counter enable mask |
| scnt_en_i | input | 32 | Supervisor-owned counter enable mask |
| hcnt_en_i | input | 32 | Hypervisor-owned counter enable mask |
| illegal_o | output | 1 | 1 when the read must raise an illegal-instruction exception |

## Verification
Immediate assertions in the top module re-check several rules on every evaluation: addresses outside the windows stay clean, high halves are rejected in 64-bit mode, machine mode passes low halves, and a permitted user or guest read always has its supervisor and hypervisor bits set. Some properties only show up when the bench compares `illegal_o` against its own model across every counter address, every privilege code, both widths and both virtualization states. These are that each address picks exactly its own bit and not a neighbour's, that high halves share the low-half bit, and that the reserved code behaves like supervisor mode. The bench drives enable patterns with the selected bit cleared or alone to expose these cases.

// File: rtl/counter_access_pkg.sv
package counter_access_pkg;

    localparam int CTR_NUM   = 32;
    localparam int CTR_IDX_W = $clog2(CTR_NUM);

    typedef enum logic [1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPER = 2'd1,
        PRIV_RSVD  = 2'd2,
        PRIV_MACH  = 2'd3
    } priv_e;

    typedef struct packed {
        logic                 hit;    // address lies in a counter window
        logic                 upper;  // high-half window
        logic [CTR_IDX_W-1:0] idx;    // enable bit index
    } ctr_sel_t;

    typedef struct packed {
        logic mode_ok;
        logic virt_ok;
        logic width_ok;
        logic illegal;
    } gate_t;

endpackage

// File: rtl/counter_addr_decode.sv
module counter_addr_decode
    import counter_access_pkg::*;
#(
    parameter int          ADDR_W  = 12,
    parameter logic [11:0] LO_BASE = 12'hC00,
    parameter logic [11:0] HI_BASE = 12'hC80
) (
    input  logic [ADDR_W-1:0] addr_i,
    output ctr_sel_t          sel_o
);
    localparam int TAG_W = ADDR_W - CTR_IDX_W;

    logic lo_hit, hi_hit;

    always_comb begin
        lo_hit = (addr_i[ADDR_W-1:CTR_IDX_W] == LO_BASE[ADDR_W-1:CTR_IDX_W]);
        hi_hit = (addr_i[ADDR_W-1:CTR_IDX_W] == HI_BASE[ADDR_W-1:CTR_IDX_W]);
        sel_o.hit   = lo_hit | hi_hit;
        sel_o.upper = hi_hit;
        sel_o.idx   = addr_i[CTR_IDX_W-1:0];
    end

    // TAG_W kept for readability of the window width
    initial begin
        assert (TAG_W > 0) else $error("address narrower than counter index");
    end
endmodule

// File: rtl/counter_enable_pick.sv
module counter_enable_pick
    import counter_access_pkg::*;
#(
    parameter int NUM = CTR_NUM,
    localparam int IW = $clog2(NUM)
) (
    input  logic [NUM-1:0] mask_i,
    input  logic [IW-1:0]  idx_i,
    output logic           bit_o
);
    always_comb bit_o = mask_i[idx_i];
endmodule

// File: rtl/counter_csr_gate.sv
module counter_csr_gate
    import counter_access_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NUM    = CTR_NUM
) (
    input  logic [ADDR_W-1:0] csr_addr_i,
    input  logic [1:0]        priv_i,
    input  logic              rv32_i,
    input  logic              virt_i,
    input  logic [NUM-1:0]    mcnt_en_i,
    input  logic [NUM-1:0]    scnt_en_i,
    input  logic [NUM-1:0]    hcnt_en_i,
    output logic              illegal_o
);
    localparam int NMASK = 3;   // 0 machine, 1 supervisor, 2 hypervisor

    ctr_sel_t                   sel;
    logic [NMASK-1:0][NUM-1:0]  masks;
    logic [NMASK-1:0]           en_bit;
    gate_t                      gate_d;
    priv_e                      priv;

    assign masks = {hcnt_en_i, scnt_en_i, mcnt_en_i};
    assign priv  = priv_e'(priv_i);

    counter_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i (csr_addr_i),
        .sel_o  (sel)
    );

    for (genvar g = 0; g < NMASK; g++) begin : g_pick
        counter_enable_pick #(.NUM(NUM)) u_pick (
            .mask_i (masks[g]),
            .idx_i  (sel.idx),
            .bit_o  (en_bit[g])
        );
    end

    always_comb begin
        gate_d = '0;
        unique case (priv)
            PRIV_MACH:  gate_d.mode_ok = 1'b1;
            PRIV_USER:  gate_d.mode_ok = en_bit[0] & en_bit[1];
            default:    gate_d.mode_ok = en_bit[0];   // supervisor and reserved
        endcase
        gate_d.virt_ok  = !(virt_i && priv != PRIV_MACH) || en_bit[2];
        gate_d.width_ok = !sel.upper || rv32_i;
        gate_d.illegal  = sel.hit &
                          !(gate_d.width_ok & gate_d.mode_ok & gate_d.virt_ok);
    end

    assign illegal_o = gate_d.illegal;

    // Assertions next to the gating logic
    always_comb begin
        // R1: outside both windows nothing is flagged
        a_r1_outside_clean: assert (
            (csr_addr_i[ADDR_W-1:5] != 7'h60 && csr_addr_i[ADDR_W-1:5] != 7'h64)
            -> !illegal_o);
        // R4: high halves rejected in 64-bit mode
        a_r4_rv64_upper: assert (
            (csr_addr_i[ADDR_W-1:5] == 7'h64 && !rv32_i) -> illegal_o);
        // R5: machine mode passes every low-half counter
        a_r5_mach_lower_ok: assert (
            (csr_addr_i[ADDR_W-1:5] == 7'h60 && priv_i == 2'b11) -> !illegal_o);
        // R7: a permitted user read had its supervisor bit set
        a_r7_user_scnt: assert (
            (csr_addr_i[ADDR_W-1:5] == 7'h60 && priv_i == 2'b00 && !illegal_o)
            -> scnt_en_i[csr_addr_i[4:0]]);
        // R9: a permitted guest read below machine had its hypervisor bit set
        a_r9_virt_hcnt: assert (
            (csr_addr_i[ADDR_W-1:5] == 7'h60 && virt_i && priv_i != 2'b11 && !illegal_o)
            -> hcnt_en_i[csr_addr_i[4:0]]);
    end
endmodule

// File: tb/counter_csr_gate_tb.sv
module counter_csr_gate_tb_top;

    typedef struct {
        logic  exp;
        string tag;
        logic [11:0] addr;
        logic [1:0]  priv;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] addr;
    logic [1:0]  priv;
    logic        rv32, virt;
    logic [31:0] m_en, s_en, h_en;
    logic        illegal;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    item_t q[$];

    always #2 clk = ~clk;   // 250 MHz

    counter_csr_gate dut_i (
        .csr_addr_i (addr), .priv_i (priv), .rv32_i (rv32), .virt_i (virt),
        .mcnt_en_i (m_en), .scnt_en_i (s_en), .hcnt_en_i (h_en),
        .illegal_o (illegal)
    );

    // Independent reference model; returns tag of deciding rule
    function automatic void model(input logic [11:0] a, input logic [1:0] p,
                                  input logic w32, input logic v,
                                  input logic [31:0] me, se, he,
                                  output logic ill, output string tag);
        int n;
        bit hi;
        ill = 1'b0;
        if (a >= 12'hC00 && a <= 12'hC1F) begin
            n = int'(a) - 'hC00; hi = 0; tag = "R2";
        end else if (a >= 12'hC80 && a <= 12'hC9F) begin
            n = int'(a) - 'hC80; hi = 1; tag = "R3";
        end else begin
            tag = "R1"; return;
        end
        if (hi && !w32) begin ill = 1'b1; tag = "R4"; return; end
        if (p == 2'b11) begin tag = "R5"; return; end
        if (p == 2'b00) begin
            if (!(me[n] && se[n])) begin ill = 1'b1; tag = "R7"; return; end
        end else if (!me[n]) begin
            ill = 1'b1; tag = (p == 2'b10) ? "R8" : "R6"; return;
        end
        if (v && !he[n]) begin ill = 1'b1; tag = "R9"; return; end
        if (!v && !he[n]) tag = "R9";
    endfunction

    task automatic drive(input logic [11:0] a, input logic [1:0] p,
                         input logic w32, input logic v,
                         input logic [31:0] me, se, he);
        item_t it;
        @(negedge clk);
        addr = a; priv = p; rv32 = w32; virt = v;
        m_en = me; s_en = se; h_en = he;
        model(a, p, w32, v, me, se, he, it.exp, it.tag);
        it.addr = a; it.priv = p;
        q.push_back(it);
    endtask

    // Monitor: compares at the rising edge, half a period after driving
    initial begin
        forever begin
            @(posedge clk);
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                total++;
                if (illegal !== it.exp) begin
                    bad++;
                    $display("FAIL %s addr=%h priv=%0d actual=%b expected=%b",
                             it.tag, it.addr, it.priv, illegal, it.exp);
                end
            end
        end
    end

    initial begin
        addr = '0; priv = '0; rv32 = 0; virt = 0;
        m_en = '0; s_en = '0; h_en = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        total++;   // reset-state check, R1
        if (illegal !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset actual=%b expected=0", illegal);
        end
        begin
            logic [11:0] extra [8] = '{12'h000, 12'hBFF, 12'hC20, 12'hC7F,
                                       12'hCA0, 12'hFFF, 12'hB00, 12'hC40};
            for (int e = 0; e < 8; e++)
                for (int p = 0; p < 4; p++)
                    drive(extra[e], 2'(p), 1'b1, 1'b1, '0, '0, '0);
        end
        for (int a = 0; a < 64; a++) begin
            logic [11:0] ad;
            int n;
            n  = a % 32;
            ad = (a < 32) ? 12'(12'hC00 + n) : 12'(12'hC80 + n);
            for (int p = 0; p < 4; p++)
                for (int w = 0; w < 2; w++)
                    for (int v = 0; v < 2; v++)
                        for (int k = 0; k < 8; k++) begin
                            logic [31:0] one, me, se, he;
                            one = 32'd1 << n;
                            me = '1; se = '1; he = '1;
                            case (k)
                                0: ;
                                1: begin me = '0; se = '0; he = '0; end
                                2: me = ~one;
                                3: se = ~one;
                                4: he = ~one;
                                5: begin me = one; se = one; he = one; end
                                6: begin me = one; se = ~one; end
                                default: begin me = ~one; se = one; he = one; end
                            endcase
                            drive(ad, 2'(p), w[0], v[0], me, se, he);
                        end
        end
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule